// File: doc/BRIEF.md
# UART Serial Receive Engine with Majority-Vote Sampling

This block turns an asynchronous serial line into parallel characters for a 16550-style UART. It runs on the system clock and advances only on a one-cycle enable, `tick16`, which pulses sixteen times per bit period. The line passes through a two-flop synchroniser. The receiver then waits for a low level, confirms it as a genuine start bit at mid-bit, and decides every later bit by a two-of-three vote over sub-bit samples 7, 8 and 9.

Word length (5 to 8 bits, least significant bit first) and parity (none, even or odd) are captured when each start bit is detected. Each finished character is placed in a one-entry holding register together with parity, framing and break flags. `rx_ready` stays high until the consumer pulses `rx_take`. A character that finishes while the holding register is still full is dropped, and `rx_overrun` pulses for one cycle. The receiver checks only the first stop bit, so the number of stop bits a transmitter sends has no effect on it.

Top module: `uart_rx_mv`

## Requirements
- R1: While reset is low and in the first cycle after it, `rx_ready` and `rx_overrun` are 0.
- R2: After the synchroniser, the line is sampled on the 7th, 8th and 9th `tick16` pulses of each bit, counting from 0 at the pulse that detected the start. The bit takes the value held by at least two of those three samples, so a disturbance that covers one sample is ignored and one that covers two decides the bit.
- R3: A start is accepted only if the start bit votes low. If it votes high, the receiver returns to idle without producing a character and accepts the next valid frame normally.
- R4: `cfg_len` selects the word length: 0→5, 1→6, 2→7, 3→8 bits. Bits arrive least significant first. `rx_data` is right-aligned, and the bits above the word length read 0.
- R5: When `cfg_par_en`=1, one parity bit follows the data. `cfg_par_odd`=0 expects an even count of ones over data plus parity, and 1 expects an odd count. A mismatch sets `rx_perr`. With parity disabled, `rx_perr` is 0.
- R6: A first stop bit that votes low sets `rx_ferr`. After such a character, no new start is accepted until the line has returned high.
- R7: If every data, parity and stop bit votes low, `rx_brk`=1, `rx_ferr`=1 and `rx_data`=0.
- R8: After a character is accepted, `rx_ready`=1 and the data and flags stay stable until `rx_take` is pulsed. That pulse clears `rx_ready` on the next cycle.
- R9: If a character completes while `rx_ready`=1 and `rx_take`=0, `rx_overrun` pulses for one cycle, the new character is discarded, and the held character is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | One-cycle enable at 16x the bit rate |
| rx_serial | input | 1 | Asynchronous serial input, idle high |
| cfg_len | input | 2 | Word length code (0..3 → 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even |
| rx_take | input | 1 | Consumer has taken the held character |
| rx_data | output | 8 | Held character, right-aligned |
| rx_perr | output | 1 | Parity error for the held character |
| rx_ferr | output | 1 | Framing error for the held character |
| rx_brk | output | 1 | Break detected for the held character |
| rx_ready | output | 1 | Holding register full |
| rx_overrun | output | 1 | One-cycle pulse: a character was lost |

## Verification
The bench builds the block with its default parameters: 16 sub-bit ticks, a vote centred on tick 8, and a two-stage synchroniser. It drives `tick16` on every fourth clock and starts each frame in a fixed phase relative to that enable, so every sub-bit sample falls on a known clock. This alignment lets the bench place a four-clock disturbance on exactly one vote sample, or an eight-clock one on two, and shape low pulses that end just before or just after the 7th sample of a start bit. Those cases exercise both outcomes of the vote and of the false-start check.

// File: rtl/uart_rx_mv_pkg.sv
// Shared types for the majority-vote UART receiver.
// Assumes characters of MIN_W..DATA_W bits, selected by a 2-bit code.
package uart_rx_mv_pkg;

    localparam int DATA_W = 8;
    localparam int MIN_W  = 5;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PARITY,
        RX_STOP,
        RX_HOLD_LOW
    } rx_state_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              brk;
    } rx_char_t;

endpackage

// File: rtl/uart_rx_mv_sync.sv
// Multi-flop synchroniser for the asynchronous serial input.
// Assumes STAGES >= 2. Resets to the idle line level so that reset
// release cannot look like a start bit.
module uart_rx_mv_sync #(
    parameter int   STAGES     = 2,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the raw input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= {STAGES{IDLE_LEVEL}};
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/uart_rx_mv_vote.sv
// Two-of-three bit decision over sub-bit samples MID-1, MID and MID+1.
// Assumes the caller supplies the sub-bit phase, which equals the index of
// the sample taken on the current tick.
module uart_rx_mv_vote #(
    parameter int OSR = 16,
    parameter int MID = 8,
    parameter int PW  = $clog2(OSR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] phase,
    input  logic          line,
    output logic          decide,
    output logic          bit_val
);
    localparam logic [PW-1:0] P_EARLY  = PW'(MID - 1);
    localparam logic [PW-1:0] P_CENTRE = PW'(MID);
    localparam logic [PW-1:0] P_LATE   = PW'(MID + 1);

    logic s_early, s_centre;

    // Capture the two earlier samples of the voting window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_early  <= 1'b1;
            s_centre <= 1'b1;
        end else if (tick && phase == P_EARLY) begin
            s_early  <= line;
        end else if (tick && phase == P_CENTRE) begin
            s_centre <= line;
        end
    end

    // The third sample is the live line; the decision is made on that tick.
    assign decide  = tick && (phase == P_LATE);
    assign bit_val = (s_early & s_centre) | (s_early & line) | (s_centre & line);
endmodule

// File: rtl/uart_rx_mv_frame.sv
// Frame sequencer: start validation, data assembly, parity and stop check.
// Assumes a synchronised line and a one-cycle tick at OSR x bit rate.
// Settings are latched when a start is detected.
module uart_rx_mv_frame
    import uart_rx_mv_pkg::*;
#(
    parameter int OSR = 16,
    parameter int MID = 8
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     tick,
    input  logic     line,
    input  logic [1:0] cfg_len,
    input  logic     cfg_par_en,
    input  logic     cfg_par_odd,
    output logic     char_done,
    output rx_char_t char_q
);
    localparam int PW = $clog2(OSR);
    localparam int BW = $clog2(DATA_W);

    rx_state_e         state;
    logic [PW-1:0]     phase;
    logic [BW-1:0]     bit_idx;
    logic [DATA_W-1:0] shreg;
    logic              acc, any_one;
    logic [1:0]        len_q;
    logic              pen_q, podd_q;
    logic              decide, bit_val;
    logic              last_data;

    uart_rx_mv_vote #(.OSR(OSR), .MID(MID), .PW(PW)) u_vote (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .phase  (phase),
        .line   (line),
        .decide (decide),
        .bit_val(bit_val)
    );

    assign last_data = (bit_idx == BW'(MIN_W - 1 + int'(len_q)));

    // Bit-level sequencing and character assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            phase     <= '0;
            bit_idx   <= '0;
            shreg     <= '0;
            acc       <= 1'b0;
            any_one   <= 1'b0;
            len_q     <= '0;
            pen_q     <= 1'b0;
            podd_q    <= 1'b0;
            char_done <= 1'b0;
            char_q    <= '0;
        end else begin
            char_done <= 1'b0;
            if (tick && state != RX_IDLE && state != RX_HOLD_LOW)
                phase <= phase + 1'b1;
            case (state)
                RX_IDLE: if (tick && !line) begin
                    state  <= RX_START;
                    phase  <= PW'(1);
                    len_q  <= cfg_len;
                    pen_q  <= cfg_par_en;
                    podd_q <= cfg_par_odd;
                end
                RX_START: if (decide) begin
                    if (bit_val) begin
                        state <= RX_IDLE;
                    end else begin
                        state   <= RX_DATA;
                        bit_idx <= '0;
                        acc     <= 1'b0;
                        any_one <= 1'b0;
                    end
                end
                RX_DATA: if (decide) begin
                    shreg   <= {bit_val, shreg[DATA_W-1:1]};
                    acc     <= acc ^ bit_val;
                    any_one <= any_one | bit_val;
                    bit_idx <= bit_idx + 1'b1;
                    if (last_data) state <= pen_q ? RX_PARITY : RX_STOP;
                end
                RX_PARITY: if (decide) begin
                    acc     <= acc ^ bit_val;
                    any_one <= any_one | bit_val;
                    state   <= RX_STOP;
                end
                RX_STOP: if (decide) begin
                    char_done   <= 1'b1;
                    char_q.data <= shreg >> (DATA_W - MIN_W - int'(len_q));
                    char_q.perr <= pen_q & (acc ^ podd_q);
                    char_q.ferr <= ~bit_val;
                    char_q.brk  <= ~bit_val & ~any_one;
                    state       <= bit_val ? RX_IDLE : RX_HOLD_LOW;
                end
                RX_HOLD_LOW: if (line) state <= RX_IDLE;
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/uart_rx_mv.sv
// Top of the majority-vote UART receiver: synchroniser, frame sequencer
// and a one-entry holding register with overrun detection.
// Assumes tick16 is a single-cycle pulse at 16x the bit rate.
module uart_rx_mv
    import uart_rx_mv_pkg::*;
#(
    parameter int OSR         = 16,
    parameter int MID         = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              rx_serial,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              rx_take,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_perr,
    output logic              rx_ferr,
    output logic              rx_brk,
    output logic              rx_ready,
    output logic              rx_overrun
);
    logic     line_s;
    logic     frm_done;
    rx_char_t frm_char, held;

    uart_rx_mv_sync #(.STAGES(SYNC_STAGES), .IDLE_LEVEL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (rx_serial),
        .q    (line_s)
    );

    uart_rx_mv_frame #(.OSR(OSR), .MID(MID)) u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick16),
        .line       (line_s),
        .cfg_len    (cfg_len),
        .cfg_par_en (cfg_par_en),
        .cfg_par_odd(cfg_par_odd),
        .char_done  (frm_done),
        .char_q     (frm_char)
    );

    // Holding register: accept when empty or being emptied, else flag overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held       <= '0;
            rx_ready   <= 1'b0;
            rx_overrun <= 1'b0;
        end else begin
            rx_overrun <= 1'b0;
            if (frm_done) begin
                if (!rx_ready || rx_take) begin
                    held     <= frm_char;
                    rx_ready <= 1'b1;
                end else begin
                    rx_overrun <= 1'b1;
                end
            end else if (rx_take) begin
                rx_ready <= 1'b0;
            end
        end
    end

    assign rx_data = held.data;
    assign rx_perr = held.perr;
    assign rx_ferr = held.ferr;
    assign rx_brk  = held.brk;
endmodule

// File: rtl/uart_rx_mv_chk.sv
// Property checker for uart_rx_mv, attached with bind.
module uart_rx_mv_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_take,
    input logic       frm_done,
    input logic [7:0] rx_data,
    input logic       rx_ferr,
    input logic       rx_brk,
    input logic       rx_ready,
    input logic       rx_overrun
);
    // R9
    overrun_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overrun |-> (rx_ready && $past(rx_ready)));

    // R8
    take_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_take && !frm_done) |=> !rx_ready);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && !rx_take) |=> (rx_ready && $stable(rx_data) && $stable(rx_ferr)));

    // R7
    break_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && rx_brk) |-> (rx_data == 8'h00 && rx_ferr));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!rx_ready && !rx_overrun));
endmodule

bind uart_rx_mv uart_rx_mv_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_take   (rx_take),
    .frm_done  (frm_done),
    .rx_data   (rx_data),
    .rx_ferr   (rx_ferr),
    .rx_brk    (rx_brk),
    .rx_ready  (rx_ready),
    .rx_overrun(rx_overrun)
);

// File: tb/uart_rx_mv_bench.sv
`timescale 1ns/1ps
module uart_rx_mv_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick16 = 1'b0;
    logic       rx_serial = 1'b1;
    logic [1:0] cfg_len = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       rx_take = 1'b0;
    logic [7:0] rx_data;
    logic       rx_perr, rx_ferr, rx_brk, rx_ready, rx_overrun;

    int checks = 0, fails = 0, cyc = 0, ovr_seen = 0, mon_prints = 0;
    bit done = 0, mon_en = 0;
    logic [7:0] e_data = 8'h00;
    logic       e_perr = 0, e_ferr = 0, e_brk = 0;

    uart_rx_mv u_uart_rx_mv (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_serial(rx_serial),
        .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .rx_take(rx_take), .rx_data(rx_data), .rx_perr(rx_perr),
        .rx_ferr(rx_ferr), .rx_brk(rx_brk), .rx_ready(rx_ready),
        .rx_overrun(rx_overrun)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    // Enable pulses on every posedge whose index is 3 mod 4.
    always @(negedge clk) tick16 <= ((cyc + 1) % 4 == 3);

    // Reference comparison on every clock: the held character must match the
    // last one the bench expects to be accepted (R8); overrun pulses are counted.
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            if (rx_ready && {rx_data, rx_perr, rx_ferr, rx_brk} !== {e_data, e_perr, e_ferr, e_brk}) begin
                checks++; fails++;
                if (mon_prints < 5)
                    $display("FAIL R8 held char: actual %h/%b%b%b expected %h/%b%b%b",
                             rx_data, rx_perr, rx_ferr, rx_brk, e_data, e_perr, e_ferr, e_brk);
                mon_prints++;
            end
            if (rx_overrun) ovr_seen++;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_char(input string req, input logic [7:0] d,
                              input bit p, input bit f, input bit b);
        check(req, "ready", int'(rx_ready), 1);
        check(req, "data", int'(rx_data), int'(d));
        check(req, "perr", int'(rx_perr), int'(p));
        check(req, "ferr", int'(rx_ferr), int'(f));
        check(req, "brk", int'(rx_brk), int'(b));
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic align();
        @(negedge clk);
        while ((cyc + 1) % 4 != 0) @(negedge clk);
    endtask

    task automatic take();
        rx_take = 1'b1;
        step(1);
        rx_take = 1'b0;
    endtask

    task automatic set_exp(input logic [7:0] d, input bit p, input bit f, input bit b);
        e_data = d; e_perr = p; e_ferr = f; e_brk = b;
    endtask

    // Send one frame using the current settings. A disturbance of glen clocks
    // starting goff clocks into bit index gbit inverts the line (gbit<0: none).
    task automatic send_frame(input logic [7:0] d, input bit flip_par, input bit stopv,
                              input int gbit, input int goff, input int glen);
        logic bits[12];
        int   nb = 0;
        int   wl = 5 + int'(cfg_len);
        logic par = cfg_par_odd ^ flip_par;
        bits[nb++] = 1'b0;
        for (int i = 0; i < wl; i++) begin
            bits[nb++] = d[i];
            par ^= d[i];
        end
        if (cfg_par_en) bits[nb++] = par;
        bits[nb++] = stopv;
        align();
        for (int b = 0; b < nb; b++) begin
            for (int k = 0; k < 64; k++) begin
                if (b == gbit && k >= goff && k < goff + glen) rx_serial = ~bits[b];
                else rx_serial = bits[b];
                @(negedge clk);
            end
        end
    endtask

    initial begin
        int ovr0;
        step(6);
        // R1: reset state
        check("R1", "ready in reset", int'(rx_ready), 0);
        check("R1", "overrun in reset", int'(rx_overrun), 0);
        rst_n = 1'b1;
        step(1);
        check("R1", "ready after reset", int'(rx_ready), 0);
        mon_en = 1;
        step(40);

        // R4: 8-bit, no parity, LSB first
        cfg_len = 2'd3; cfg_par_en = 0;
        set_exp(8'hA5, 0, 0, 0);
        send_frame(8'hA5, 0, 1, -1, 0, 0);
        check_char("R4", 8'hA5, 0, 0, 0);
        // R8: stays held until taken, then clears
        step(200);
        check("R8", "ready held", int'(rx_ready), 1);
        take();
        check("R8", "ready after take", int'(rx_ready), 0);

        // R4 R5: 5-bit even parity, correct
        cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0;
        set_exp(8'h13, 0, 0, 0);
        send_frame(8'h13, 0, 1, -1, 0, 0);
        check_char("R4", 8'h13, 0, 0, 0);
        take();
        // R5: 7-bit odd parity, correct
        cfg_len = 2'd2; cfg_par_odd = 1;
        set_exp(8'h55, 0, 0, 0);
        send_frame(8'h55, 0, 1, -1, 0, 0);
        check_char("R5", 8'h55, 0, 0, 0);
        take();
        // R5: 6-bit even parity, wrong bit
        cfg_len = 2'd1; cfg_par_odd = 0;
        set_exp(8'h2A, 1, 0, 0);
        send_frame(8'h2A, 1, 1, -1, 0, 0);
        check_char("R5", 8'h2A, 1, 0, 0);
        take();
        // R5: 8-bit odd parity, wrong bit
        cfg_len = 2'd3; cfg_par_odd = 1;
        set_exp(8'hC3, 1, 0, 0);
        send_frame(8'hC3, 1, 1, -1, 0, 0);
        check_char("R5", 8'hC3, 1, 0, 0);
        take();

        // R2: disturbance on one vote sample of data bit 2 is outvoted
        cfg_par_en = 0;
        set_exp(8'hFF, 0, 0, 0);
        send_frame(8'hFF, 0, 1, 3, 32, 4);
        check_char("R2", 8'hFF, 0, 0, 0);
        take();
        // R2: disturbance on two vote samples decides the bit
        set_exp(8'hFB, 0, 0, 0);
        send_frame(8'hFF, 0, 1, 3, 28, 8);
        check_char("R2", 8'hFB, 0, 0, 0);
        take();

        // R3: low pulse ending before sample 7 of the start bit
        align();
        rx_serial = 0; step(24); rx_serial = 1; step(200);
        check("R3", "ready after short low", int'(rx_ready), 0);
        // R3: low covering sample 7 only; vote is still high
        align();
        rx_serial = 0; step(32); rx_serial = 1; step(200);
        check("R3", "ready after one-sample low", int'(rx_ready), 0);
        set_exp(8'h3C, 0, 0, 0);
        send_frame(8'h3C, 0, 1, -1, 0, 0);
        check_char("R3", 8'h3C, 0, 0, 0);
        take();

        // R6: low stop bit, then line stays low
        set_exp(8'h81, 0, 1, 0);
        send_frame(8'h81, 0, 0, -1, 0, 0);
        check_char("R6", 8'h81, 0, 1, 0);
        take();
        step(400);
        check("R6", "no restart while low", int'(rx_ready), 0);
        rx_serial = 1; step(64);
        set_exp(8'h5A, 0, 0, 0);
        send_frame(8'h5A, 0, 1, -1, 0, 0);
        check_char("R6", 8'h5A, 0, 0, 0);
        take();

        // R7: all-low frame, 8 bits no parity
        set_exp(8'h00, 0, 1, 1);
        send_frame(8'h00, 0, 0, -1, 0, 0);
        check_char("R7", 8'h00, 0, 1, 1);
        take();
        rx_serial = 1; step(64);
        // R7: all-low frame, 7 bits odd parity (parity bit 0 -> also perr)
        cfg_len = 2'd2; cfg_par_en = 1; cfg_par_odd = 1;
        set_exp(8'h00, 1, 1, 1);
        send_frame(8'h00, 1, 0, -1, 0, 0);
        check_char("R7", 8'h00, 1, 1, 1);
        take();
        rx_serial = 1; step(64);

        // R9: second character while the first is still held
        cfg_len = 2'd3; cfg_par_en = 0;
        set_exp(8'h11, 0, 0, 0);
        send_frame(8'h11, 0, 1, -1, 0, 0);
        check_char("R9", 8'h11, 0, 0, 0);
        ovr0 = ovr_seen;
        send_frame(8'h22, 0, 1, -1, 0, 0);
        check("R9", "overrun pulses", ovr_seen - ovr0, 1);
        check_char("R9", 8'h11, 0, 0, 0);
        take();
        check("R9", "ready after take", int'(rx_ready), 0);
        check("R9", "no further overrun", ovr_seen - ovr0, 1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule